// File: doc/BRIEF.md
# Biphase Transmit Line Encoder

The block turns a serial stream of NRZ transmit bits into a biphase (Manchester) line signal for a cellular control channel. Every bit period has two halves, and a single-cycle clock enable, `half_en`, marks each half. The half-bit enable that starts a bit period samples the data bit and the mode inputs. The half-bit enable that follows produces the second half. The block can flip the whole line stream at run time, so the same encoder can drive a modulator with either a high or a low local oscillator. In bypass mode the raw data goes straight to the line without encoding.

The block also has a transmitter kill for failed access attempts. A single-cycle failure pulse latches a condition that pulls the transmit-allow output low. That output is meant to drive an open-drain pull-down stage. It stays low until software asserts a clear.

Top module: `biphase_tx_encoder`

## Requirements
- R1: After reset, `line_out` equals the idle level `IDLE_LVL` (default 0) and `tx_allow` is 1. Nothing changes on the line until the first `half_en`.
- R2: With `pol_n` = 1 and bypass off, an active bit of value 1 puts 0 on the line for the first half and 1 for the second half. This is a rising transition at the bit centre.
- R3: With `pol_n` = 1 and bypass off, an active bit of value 0 puts 1 on the line for the first half and 0 for the second half.
- R4: When `pol_n` is 0 at a bit boundary, both halves of that bit period are inverted. This covers encoded data, bypassed data and the idle level.
- R5: When `bypass` is 1 and the bit is active, both halves carry the data bit unchanged. Inversion under R4 still applies.
- R6: A bit is active only if `stream_en` and `din_valid` are both 1 at the bit boundary. Otherwise both halves carry the idle level, after inversion. This applies with or without bypass.
- R7: `din`, `din_valid`, `stream_en`, `bypass` and `pol_n` are sampled only at a bit boundary. Changing them before the second half has no effect on that half.
- R8: `line_out` changes only in the clock cycle after a `half_en` pulse. Between pulses it holds its value.
- R9: A `fail_pulse` drives `tx_allow` to 0 one cycle later. It stays 0 until `fail_clr`, and a pulse and a clear in the same cycle leave it at 0.
- R10: A `fail_clr` with no `fail_pulse` drives `tx_allow` to 1 one cycle later. A clear while already enabled keeps it at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_en | input | 1 | Single-cycle enable, one per half-bit |
| din | input | 1 | NRZ data bit |
| din_valid | input | 1 | Data bit is present at this boundary |
| stream_en | input | 1 | Transmit stream enable |
| bypass | input | 1 | 1 sends raw data without encoding |
| pol_n | input | 1 | 0 inverts the line stream |
| fail_pulse | input | 1 | Access-failure strobe, kills the transmitter |
| fail_clr | input | 1 | Software clear of the kill condition |
| line_out | output | 1 | Registered biphase line output |
| tx_allow | output | 1 | 0 disables RF (drives an open-drain pull-down) |

## Verification
The checker relies on `half_en` being a single-cycle pulse with at least one idle cycle between pulses. It also relies on a bit period always being two consecutive pulses, so the first pulse after reset is a bit boundary. The bench produces every pulse through one task that raises `half_en` for exactly one cycle and then waits, so that assumption always holds. During the second half the bench toggles every sampled input, so any leak of live inputs into the held bit shows on the line. It sweeps all 32 combinations of data, valid, stream enable, bypass and polarity.

// File: rtl/biphase_tx_encoder.sv
module biphase_tx_encoder #(
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_en,
  input  logic din,
  input  logic din_valid,
  input  logic stream_en,
  input  logic bypass,
  input  logic pol_n,
  input  logic fail_pulse,
  input  logic fail_clr,
  output logic line_out,
  output logic tx_allow
);

  logic sec, bit_q, act_q, byp_q, inv_q, killed, raw, inv;

  wire bnd     = half_en & ~sec;
  wire act_now = stream_en & din_valid;

  always_comb begin
    if (bnd) begin
      inv = ~pol_n;
      if (!act_now)    raw = IDLE_LVL;
      else if (bypass) raw = din;
      else             raw = ~din;
    end else begin
      inv = inv_q;
      raw = act_q ? bit_q : IDLE_LVL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec      <= 1'b0;
      bit_q    <= 1'b0;
      act_q    <= 1'b0;
      byp_q    <= 1'b0;
      inv_q    <= 1'b0;
      line_out <= IDLE_LVL;
    end else if (half_en) begin
      sec      <= ~sec;
      line_out <= raw ^ inv;
      if (bnd) begin
        bit_q <= din;
        act_q <= act_now;
        byp_q <= bypass;
        inv_q <= ~pol_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          killed <= 1'b0;
    else if (fail_pulse) killed <= 1'b1;
    else if (fail_clr)   killed <= 1'b0;
  end

  assign tx_allow = ~killed;

endmodule

// File: rtl/biphase_tx_checker.sv
module biphase_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic half_en,
  input logic fail_pulse,
  input logic fail_clr,
  input logic line_out,
  input logic tx_allow,
  input logic sec,
  input logic act_q,
  input logic byp_q
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  p_centre_edge_r2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && half_en && sec && act_q && !byp_q |=> line_out != $past(line_out));

  p_bypass_flat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && half_en && sec && act_q && byp_q |=> $stable(line_out));

  p_idle_flat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && half_en && sec && !act_q |=> $stable(line_out));

  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !half_en |=> $stable(line_out));

  p_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pulse |=> !tx_allow);

  p_kill_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_allow && !fail_clr |=> !tx_allow);

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fail_clr && !fail_pulse |=> tx_allow);

endmodule

bind biphase_tx_encoder biphase_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .half_en(half_en), .fail_pulse(fail_pulse),
  .fail_clr(fail_clr), .line_out(line_out), .tx_allow(tx_allow),
  .sec(sec), .act_q(act_q), .byp_q(byp_q)
);

// File: tb/test_biphase_tx_encoder.sv
`timescale 1ns/1ps
module test_biphase_tx_encoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic half_en = 0, din = 0, din_valid = 0, stream_en = 0, bypass = 0, pol_n = 1;
  logic fail_pulse = 0, fail_clr = 0;
  logic line_out, tx_allow;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  biphase_tx_encoder i_biphase_tx_encoder (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .din(din), .din_valid(din_valid),
    .stream_en(stream_en), .bypass(bypass), .pol_n(pol_n), .fail_pulse(fail_pulse),
    .fail_clr(fail_clr), .line_out(line_out), .tx_allow(tx_allow));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_half();
    @(negedge clk) half_en = 1;
    @(negedge clk) half_en = 0;
  endtask

  function automatic logic expect_half(logic d, logic v, logic se, logic by, logic pn, bit first);
    logic raw;
    if (!(se && v))  raw = 1'b0;
    else if (by)     raw = d;
    else             raw = first ? ~d : d;
    return raw ^ ~pn;
  endfunction

  initial begin
    #500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic e1, e2, held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 line idle", line_out, 1'b0);
    check("R1 tx_allow", tx_allow, 1'b1);

    for (int k = 0; k < 32; k++) begin
      logic d, v, se, by, pn;
      {d, v, se, by, pn} = k[4:0];
      @(negedge clk);
      din = d; din_valid = v; stream_en = se; bypass = by; pol_n = pn;
      e1 = expect_half(d, v, se, by, pn, 1'b1);
      e2 = expect_half(d, v, se, by, pn, 1'b0);
      pulse_half();
      check((!(se && v)) ? "R6 first half" : (by ? "R5 first half" :
            (pn ? (d ? "R2 first half" : "R3 first half") : "R4 first half")), line_out, e1);
      din = ~d; din_valid = ~v; stream_en = ~se; bypass = ~by; pol_n = ~pn;
      held = line_out;
      repeat (2) @(negedge clk);
      check("R8 hold between pulses", line_out, held);
      pulse_half();
      check((!(se && v)) ? "R6/R7 second half" : (by ? "R5/R7 second half" :
            (pn ? (d ? "R2/R7 second half" : "R3/R7 second half") : "R4/R7 second half")),
            line_out, e2);
    end

    @(negedge clk) fail_pulse = 1;
    @(negedge clk) fail_pulse = 0;
    check("R9 kill", tx_allow, 1'b0);
    repeat (5) @(negedge clk);
    check("R9 kill held", tx_allow, 1'b0);
    fail_clr = 1;
    @(negedge clk) fail_clr = 0;
    check("R10 release", tx_allow, 1'b1);
    fail_pulse = 1; fail_clr = 1;
    @(negedge clk) begin fail_pulse = 0; fail_clr = 0; end
    check("R9 pulse beats clear", tx_allow, 1'b0);
    fail_clr = 1;
    @(negedge clk);
    check("R10 release again", tx_allow, 1'b1);
    @(negedge clk) fail_clr = 0;
    check("R10 clear while enabled", tx_allow, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule